// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Controller

This block chooses the moment at which the power switch of a quasi-resonant flyback converter is turned on. Two digitized comparator flags come from the zero-current-detect input. One reports that the auxiliary winding sits above the arm level. The other reports that it has dropped below the trigger level. The block also receives an 8-bit code for the error-amplifier output and a one-cycle pulse that marks switch turn-off. It answers with a one-cycle set pulse for the PWM latch and a one-cycle strobe that tells the feedback sample-and-hold to capture the winding voltage at the end of demagnetization.

After every turn-off, a blanking window hides the early ringing valleys. The window is long at light load (low code) and short at heavy load (high code), and it scales linearly between two code end points. The first armed trigger edge after the window is accepted. The strobe fires at once, and the set pulse follows a fixed number of cycles later so that turn-on lands in the ringing minimum. A minimum spacing between set pulses caps the switching frequency. When no valid edge arrives, a fallback starter turns the switch on at a slow or fast rate chosen by the code. This also keeps the converter running in constant-current operation, when the winding voltage is too low to arm the detector.

Top module: `qr_valley_turnon`

## Requirements
- R1: While `rst_i` is high, both outputs are 0. After reset is released, no set pulse appears before the starter period, and with a code at or below `STARTER_THR` the first set pulse is seen exactly `STARTER_SLOW` cycles after the last reset cycle.
- R2: A trigger edge is a 0-to-1 change of `zcd_low_i` (1 = winding below trigger level). It is accepted only if a 0-to-1 change of `zcd_arm_i` (1 = winding above arm level) was seen in the off phase since the last set pulse.
- R3: Take E as the cycle in which `gate_off_i` is sampled high while the switch is on. Trigger edges sampled in cycles E+1 to E+B are ignored, and an edge in cycle E+B+1 or later is accepted. B is computed as follows. B = `BLANK_MAX` when code ≤ `COMP_LO`. B = `BLANK_MIN` when code ≥ `COMP_HI`. Otherwise B = `BLANK_MAX` − floor((code − `COMP_LO`)·(`BLANK_MAX` − `BLANK_MIN`)/(`COMP_HI` − `COMP_LO`)), using the code held in cycle E.
- R4: An accepted trigger edge sampled in cycle T makes `sample_strobe_o` high for exactly the one cycle after T.
- R5: After an accepted edge, `set_pulse_o` is high for one cycle, `VALLEY_DLY` cycles after the strobe, unless R6 holds it back.
- R6: Two set pulses are never closer than `MIN_PERIOD` cycles. A turn-on that is due earlier is held and issued exactly `MIN_PERIOD` cycles after the previous one.
- R7: While the switch is off and no edge has been accepted, a set pulse is issued once the time since the previous set pulse reaches the starter period. That period is `STARTER_SLOW` cycles when code ≤ `STARTER_THR` and `STARTER_FAST` cycles when code > `STARTER_THR`.
- R8: Every set pulse, from a trigger or from the starter, clears the armed condition, so each cycle needs a fresh arm edge.
- R9: Arm and trigger edges sampled while the switch is on (from a set pulse up to the turn-off sample) have no effect.
- R10: The set pulse and the strobe never overlap. A starter turn-on produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| zcd_arm_i | input | 1 | 1 when the winding sense is above the arm level |
| zcd_low_i | input | 1 | 1 when the winding sense is below the trigger level |
| gate_off_i | input | 1 | One-cycle pulse when the switch is turned off |
| comp_code_i | input | COMP_W | Error-amplifier output code, unsigned |
| set_pulse_o | output | 1 | One-cycle turn-on request to the PWM latch |
| sample_strobe_o | output | 1 | One-cycle end-of-demagnetization sample strobe |

## Verification
The bench places trigger edges exactly on the last blanked cycle and on the first open cycle, at both clamp ends and in the middle of the code range. An off-by-one window, or a slope taken from the wrong end point, would move the strobe by one or more cycles, and the bench catches that. It checks code values on both sides of the starter threshold, where a swapped or non-strict compare would show a 4000- or 1000-cycle interval instead of the expected one. It sends edges while the switch is on and in an off phase with no fresh arm. A design that remembered an old arm, or that listened during the on phase, would emit a spurious strobe. It also forces a valid edge soon after a turn-on, so that a design without the frequency cap would issue the set pulse early.

// File: rtl/qrv_pkg.sv
package qrv_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DELAY = 2'd1,
    ST_ON    = 2'd2
  } qrv_state_e;
endpackage

// File: rtl/qrv_zcd_edges.sv
// Rising-edge detection on the two digitized detector flags.
module qrv_zcd_edges #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NCH-1:0] lvl_i,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= lvl_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/qrv_blank_timer.sv
// Load-dependent blanking window, linear between two code end points.
module qrv_blank_timer #(
  parameter int COMP_W    = 8,
  parameter int BLANK_MAX = 6000,
  parameter int BLANK_MIN = 1200,
  parameter int COMP_LO   = 90,
  parameter int COMP_HI   = 130
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic              start_i,
  output logic              blanking_o
);
  localparam int BLK_W = $clog2(BLANK_MAX + 1);
  localparam int SPAN  = COMP_HI - COMP_LO;
  localparam int DROP  = BLANK_MAX - BLANK_MIN;
  localparam logic [COMP_W-1:0] LO_C  = COMP_W'(COMP_LO);
  localparam logic [COMP_W-1:0] HI_C  = COMP_W'(COMP_HI);
  localparam logic [BLK_W-1:0]  MAX_C = BLK_W'(BLANK_MAX);
  localparam logic [BLK_W-1:0]  MIN_C = BLK_W'(BLANK_MIN);

  logic [BLK_W-1:0] ticks;
  logic [BLK_W-1:0] cnt_q;
  logic [31:0]      offs;
  logic [31:0]      scaled;

  always_comb begin
    offs   = 32'(comp_i) - 32'(COMP_LO);
    scaled = (offs * 32'(DROP)) / 32'(SPAN);
    if (comp_i <= LO_C)      ticks = MAX_C;
    else if (comp_i >= HI_C) ticks = MIN_C;
    else                     ticks = BLK_W'(32'(BLANK_MAX) - scaled);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)              cnt_q <= '0;
    else if (start_i)       cnt_q <= ticks;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign blanking_o = (cnt_q != '0);

  // R3: a turn-off always opens a window
  a_r3_window_opens: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> blanking_o);
endmodule

// File: rtl/qrv_period_timer.sv
// Time since last turn-on: frequency cap and fallback starter.
module qrv_period_timer #(
  parameter int COMP_W       = 8,
  parameter int STARTER_SLOW = 100000,
  parameter int STARTER_FAST = 25000,
  parameter int STARTER_THR  = 100,
  parameter int MIN_PERIOD   = 1205
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic              restart_i,
  output logic              starter_due_o,
  output logic              period_ok_o
);
  localparam int PER_W = $clog2(STARTER_SLOW + 1);
  localparam logic [PER_W-1:0]  SLOW_C = PER_W'(STARTER_SLOW - 1);
  localparam logic [PER_W-1:0]  FAST_C = PER_W'(STARTER_FAST - 1);
  localparam logic [PER_W-1:0]  CAP_C  = PER_W'(MIN_PERIOD - 1);
  localparam logic [COMP_W-1:0] THR_C  = COMP_W'(STARTER_THR);

  logic [PER_W-1:0] cnt_q;
  logic             fast;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign fast          = (comp_i > THR_C);
  assign period_ok_o   = (cnt_q >= CAP_C);
  assign starter_due_o = (cnt_q >= (fast ? FAST_C : SLOW_C));

  // R6: a turn-on only leaves once the minimum period has run
  a_r6_min_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |-> (cnt_q >= CAP_C));
endmodule

// File: rtl/qr_valley_turnon.sv
module qr_valley_turnon
  import qrv_pkg::*;
#(
  parameter int COMP_W       = 8,
  parameter int BLANK_MAX    = 6000,
  parameter int BLANK_MIN    = 1200,
  parameter int COMP_LO      = 90,
  parameter int COMP_HI      = 130,
  parameter int STARTER_SLOW = 100000,
  parameter int STARTER_FAST = 25000,
  parameter int STARTER_THR  = 100,
  parameter int MIN_PERIOD   = 1205,
  parameter int VALLEY_DLY   = 40
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              zcd_arm_i,
  input  logic              zcd_low_i,
  input  logic              gate_off_i,
  input  logic [COMP_W-1:0] comp_code_i,
  output logic              set_pulse_o,
  output logic              sample_strobe_o
);
  localparam int DLY_W = $clog2(VALLEY_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(VALLEY_DLY - 1);

  qrv_state_e       state_q;
  logic [DLY_W-1:0] dly_q;
  logic             armed_q;
  logic             set_q;
  logic             strobe_q;
  logic [1:0]       rise;
  logic             arm_rise;
  logic             low_rise;
  logic             blanking;
  logic             starter_due;
  logic             period_ok;
  logic             off_start;
  logic             take_trig;
  logic             fire;

  qrv_zcd_edges #(.NCH(2)) u_edges (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  ({zcd_low_i, zcd_arm_i}),
    .rise_o (rise)
  );
  assign arm_rise = rise[0];
  assign low_rise = rise[1];

  assign off_start = (state_q == ST_ON) && gate_off_i;

  qrv_blank_timer #(
    .COMP_W(COMP_W), .BLANK_MAX(BLANK_MAX), .BLANK_MIN(BLANK_MIN),
    .COMP_LO(COMP_LO), .COMP_HI(COMP_HI)
  ) u_blank (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .comp_i     (comp_code_i),
    .start_i    (off_start),
    .blanking_o (blanking)
  );

  qrv_period_timer #(
    .COMP_W(COMP_W), .STARTER_SLOW(STARTER_SLOW), .STARTER_FAST(STARTER_FAST),
    .STARTER_THR(STARTER_THR), .MIN_PERIOD(MIN_PERIOD)
  ) u_period (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .comp_i        (comp_code_i),
    .restart_i     (fire),
    .starter_due_o (starter_due),
    .period_ok_o   (period_ok)
  );

  always_comb begin
    take_trig = (state_q == ST_OFF) && armed_q && !blanking && low_rise;
    fire      = ((state_q == ST_OFF) && !take_trig && starter_due && period_ok) ||
                ((state_q == ST_DELAY) && (dly_q == '0) && period_ok);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_OFF;
      dly_q    <= '0;
      set_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      set_q    <= fire;
      strobe_q <= take_trig;
      case (state_q)
        ST_ON: begin
          if (gate_off_i) state_q <= ST_OFF;
        end
        ST_OFF: begin
          if (take_trig) begin
            state_q <= ST_DELAY;
            dly_q   <= DLY_LOAD;
          end else if (fire) begin
            state_q <= ST_ON;
          end
        end
        ST_DELAY: begin
          if (dly_q != '0)  dly_q   <= dly_q - 1'b1;
          else if (fire)    state_q <= ST_ON;
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                                  armed_q <= 1'b0;
    else if (fire)                              armed_q <= 1'b0;
    else if ((state_q == ST_OFF) && arm_rise)   armed_q <= 1'b1;
  end

  assign set_pulse_o     = set_q;
  assign sample_strobe_o = strobe_q;

  // R10: turn-on request lasts one cycle
  a_r10_set_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    set_pulse_o |=> !set_pulse_o);
  // R10: strobe and turn-on never coincide
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
    !(set_pulse_o && sample_strobe_o));
  // R8: arming never survives a turn-on
  a_r8_arm_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
    set_pulse_o |-> !armed_q);
  // R9: no strobe while the switch is on
  a_r9_on_no_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_ON) |-> !sample_strobe_o);
  // R5: a strobe is always followed by the valley delay
  a_r5_strobe_in_delay: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_strobe_o |-> (state_q == ST_DELAY));
endmodule

// File: tb/qr_valley_turnon_tb.sv
`timescale 1ns/1ps
module qr_valley_turnon_tb_top;
  localparam int P_SLOW = 4000;
  localparam int P_FAST = 1000;
  localparam int P_DLY  = 4;
  localparam int P_CAP  = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm = 1'b0;
  logic       low = 1'b0;
  logic       goff = 1'b0;
  logic [7:0] comp = 8'd50;
  logic       set_p;
  logic       strobe;

  int cyc = 0;
  int set_cnt = 0, strobe_cnt = 0, last_set = -1, last_strobe = -1;
  int errors = 0, total = 0;
  int rel_cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qr_valley_turnon #(
    .COMP_W(8), .BLANK_MAX(300), .BLANK_MIN(60), .COMP_LO(90), .COMP_HI(130),
    .STARTER_SLOW(P_SLOW), .STARTER_FAST(P_FAST), .STARTER_THR(100),
    .MIN_PERIOD(P_CAP), .VALLEY_DLY(P_DLY)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .zcd_arm_i(arm), .zcd_low_i(low),
    .gate_off_i(goff), .comp_code_i(comp),
    .set_pulse_o(set_p), .sample_strobe_o(strobe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (set_p)  begin set_cnt++;    last_set    = cyc; end
    if (strobe) begin strobe_cnt++; last_strobe = cyc; end
  end

  function automatic int blank_of(int c);
    if (c <= 90)  return 300;
    if (c >= 130) return 60;
    return 300 - ((c - 90) * 240) / 40;
  endfunction

  task automatic check_eq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_neg(int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic wait_set(output int s);
    int c0 = set_cnt;
    do begin @(negedge clk); #1; end while (set_cnt == c0);
    s = last_set;
  endtask

  // gate_off sampled at edge n+1
  task automatic pulse_off(int n);
    at_neg(n); goff = 1'b1; @(negedge clk); goff = 1'b0;
  endtask

  // arm flag rises at sampled edge x
  task automatic arm_at(int x);
    at_neg(x - 1); arm = 1'b1; @(negedge clk); @(negedge clk); arm = 1'b0;
  endtask

  // low flag rises at sampled edge x
  task automatic low_at(int x);
    at_neg(x - 1); low = 1'b1; @(negedge clk); @(negedge clk); low = 1'b0;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check_eq("R1 set during reset", int'(set_p), 0);
    check_eq("R1 strobe during reset", int'(strobe), 0);
    rst = 1'b0; rel_cyc = cyc;
    at_neg(rel_cyc + 100); #1;
    check_eq("R1 no early set", set_cnt, 0);
  endtask

  task automatic t_starter();
    int s0, s1, s2, s3;
    wait_set(s0);
    check_eq("R1 first starter turn-on", s0 - rel_cyc, P_SLOW);
    pulse_off(s0 + 5);
    wait_set(s1);
    check_eq("R7 slow starter", s1 - s0, P_SLOW);
    comp = 8'd100;
    pulse_off(s1 + 5);
    wait_set(s2);
    check_eq("R7 threshold code stays slow", s2 - s1, P_SLOW);
    comp = 8'd101;
    pulse_off(s2 + 5);
    wait_set(s3);
    check_eq("R7 fast starter", s3 - s2, P_FAST);
    check_eq("R10 no strobe from starter", strobe_cnt, 0);
    comp = 8'd110;
    pulse_off(s3 + 5);
  endtask

  task automatic t_valley();
    int s, e, c, t, s2, e2, sv;
    wait_set(s);
    pulse_off(s + 5); e = s + 6;
    arm_at(e + 10);
    c = strobe_cnt;
    t = e + blank_of(110) + 1;
    low_at(t);
    at_neg(t + P_DLY + 2); #1;
    check_eq("R3 first open cycle accepted", last_strobe, t);
    check_eq("R4 single strobe", strobe_cnt, c + 1);
    check_eq("R5 set after valley delay", last_set, t + P_DLY);
    sv = last_set;
    pulse_off(sv + 5); e2 = sv + 6;
    low_at(e2 + 200);
    at_neg(e2 + 210); #1;
    check_eq("R8 stale arm ignored", strobe_cnt, c + 1);
    wait_set(s2);
    check_eq("R8 starter takes over", s2 - sv, P_FAST);
    pulse_off(s2 + 5);
  endtask

  task automatic t_blank_edge();
    int s, e, c;
    comp = 8'd50;
    wait_set(s);
    pulse_off(s + 5); e = s + 6;
    arm_at(e + 10);
    c = strobe_cnt;
    low_at(e + blank_of(50));
    low_at(e + blank_of(50) + 5);
    at_neg(e + 320); #1;
    check_eq("R3 last blanked cycle ignored", last_strobe, e + 305);
    check_eq("R3 one strobe", strobe_cnt, c + 1);
    check_eq("R5 set after delay", last_set, e + 305 + P_DLY);
    pulse_off(last_set + 5);
  endtask

  task automatic t_cap();
    int s, e;
    comp = 8'd200;
    wait_set(s);
    pulse_off(s + 1); e = s + 2;
    arm_at(e + 5);
    low_at(e + blank_of(200) + 1);
    at_neg(s + 90); #1;
    check_eq("R3 lower clamp window", last_strobe, s + 63);
    check_eq("R6 frequency cap", last_set, s + P_CAP);
    pulse_off(last_set + 5);
  endtask

  task automatic t_on_ignored();
    int s, e, c, s2;
    comp = 8'd110;
    wait_set(s);
    c = strobe_cnt;
    arm_at(s + 3);
    low_at(s + 8);
    at_neg(s + 15); #1;
    check_eq("R9 edges while on", strobe_cnt, c);
    pulse_off(s + 20); e = s + 21;
    low_at(e + 200);
    at_neg(e + 210); #1;
    check_eq("R2 R9 unarmed trigger ignored", strobe_cnt, c);
    wait_set(s2);
    check_eq("R7 starter after unarmed phase", s2 - s, P_FAST);
    pulse_off(s2 + 5);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      errors++; total++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_starter();
    t_valley();
    t_blank_edge();
    t_cap();
    t_on_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule